// File: doc/BRIEF.md
# Microwire serial EEPROM slave

This block is a synthesizable, cycle-accurate model of a three-wire serial EEPROM slave that speaks the Microwire protocol. A host drives chip select, a serial clock and a data-in line. The block answers on a data-out line that has its own output-enable, which stands in for a tri-state pin. All activity is sampled on a fast system clock. The serial clock is treated as a data input, and its rising edges are found by an edge detector. The storage is an internal register array, and an organization input picks between 16-bit and 8-bit words.

Each instruction starts with a start bit. A 2-bit opcode and an address follow, and for the two write forms a data word comes last. Programming is locked until an enable instruction is given. Each programming operation keeps the device busy for a fixed number of system clock cycles. During that time the data-out line serves as a ready/busy flag.

Top module: `mw_eeprom`

## Requirements
- R1: With `org16_i` high, words are 16 bits wide and the address is 10 bits. With `org16_i` low, words are 8 bits and the address is 11 bits. Byte address 2k+1 maps to the upper half of 16-bit word k, and byte address 2k maps to its lower half.
- R2: Nothing happens until a start condition: a rising serial clock edge with both `cs_i` and `di_i` high. After it, the opcode, the address and then the data are taken from `di_i` on rising edges, MSB first.
- R3: If `cs_i` drops before the last required bit, the partial instruction is discarded and memory is unchanged.
- R4: After reset, writes are locked. WRITE, ERASE, erase-all and write-all then cause no busy period, no status output and no memory change.
- R5: Opcode 00 with top address bits 11 unlocks writes, and opcode 00 with top address bits 00 locks them again. READ works in both states.
- R6: READ (opcode 10) drives a 0 on the rising edge that takes in the last address bit. Each later rising edge then presents the next word bit, MSB first. The rising edge after the last word bit releases the output.
- R7: WRITE (opcode 01) stores the data word that follows the address. ERASE (opcode 11) sets the addressed location to all ones.
- R8: Opcode 00 with top address bits 10 sets every location to all ones. Opcode 00 with top address bits 01, followed by a data word, writes that word to every location. In 8-bit mode both halves of every word are written.
- R9: A programming operation starts on the edge of its last bit and stays busy for `PROG_CYC` system clock cycles, during which serial clock edges are ignored. While `cs_i` is high, `do_o` shows 0 when busy and 1 when ready. This status display lasts until the next start bit.
- R10: `do_oe_o` is low whenever `cs_i` is low, with no delay. It is also low while an instruction is being shifted in.
- R11: After reset every location reads all ones, and `do_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock, sampled on `clk` |
| di_i | input | 1 | Serial data in |
| org16_i | input | 1 | High for 16-bit words, low for 8-bit words |
| do_o | output | 1 | Serial data out / ready flag |
| do_oe_o | output | 1 | Output-enable for `do_o` (low means high impedance) |

## Verification
The hardest case to reach is serial clock activity, including would-be start bits, that arrives while a programming cycle is still counting down. Chip select also toggles in the middle of that countdown. The stimulus launches a write and, inside the busy window, drops and raises `cs_i` and sends start-like edges. A behavioural model expects status to stay visible and the busy count to run on undisturbed. Mixed organizations are also exercised: byte writes in 8-bit mode are read back as 16-bit words to pin down the half-word mapping.

// File: rtl/mw_pkg.sv
package mw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_OPC   = 3'd1,
        ST_ADDR  = 3'd2,
        ST_DATA  = 3'd3,
        ST_RDOUT = 3'd4,
        ST_BUSY  = 3'd5
    } mw_state_e;

    localparam logic [1:0] OP_SPECIAL = 2'b00;
    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;
    localparam logic [1:0] OP_ERASE   = 2'b11;

    localparam logic [1:0] SP_LOCK    = 2'b00;
    localparam logic [1:0] SP_FILL    = 2'b01;
    localparam logic [1:0] SP_CLEAR   = 2'b10;
    localparam logic [1:0] SP_UNLOCK  = 2'b11;
endpackage

// File: rtl/mw_edge.sv
module mw_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic sig_d, sig_q;

    always_comb sig_d = sig_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_d;
    end

    assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/mw_array.sv
module mw_array #(
    parameter int WORD_W  = 16,
    parameter int WADDR_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic               all_i,
    input  logic               full_i,
    input  logic               bsel_i,
    input  logic [WADDR_W-1:0] widx_i,
    input  logic [WORD_W-1:0]  wdata_i,
    input  logic [WADDR_W-1:0] ridx_i,
    output logic [WORD_W-1:0]  rdata_o
);
    localparam int DEPTH  = 1 << WADDR_W;
    localparam int BYTE_W = WORD_W / 2;

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) mem_q[w] <= '1;
        end else if (wr_i) begin
            for (int w = 0; w < DEPTH; w++) begin
                if (all_i || widx_i == WADDR_W'(w)) begin
                    if (all_i || full_i)
                        mem_q[w] <= wdata_i;
                    else if (bsel_i)
                        mem_q[w][WORD_W-1:BYTE_W] <= wdata_i[BYTE_W-1:0];
                    else
                        mem_q[w][BYTE_W-1:0] <= wdata_i[BYTE_W-1:0];
                end
            end
        end
    end

    assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int WADDR_W  = 10,
    parameter int PROG_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    input  logic org16_i,
    output logic do_o,
    output logic do_oe_o
);
    localparam int BYTE_W  = WORD_W / 2;
    localparam int BADDR_W = WADDR_W + 1;
    localparam int RSH_W   = WORD_W + 1;
    localparam int CMAX    = (BADDR_W > WORD_W) ? BADDR_W : WORD_W;
    localparam int CNT_W   = $clog2(CMAX + 1);
    localparam int PCNT_W  = $clog2(PROG_CYC + 1);
    localparam logic [CNT_W-1:0] AW16 = CNT_W'(WADDR_W);
    localparam logic [CNT_W-1:0] AW8  = CNT_W'(BADDR_W);
    localparam logic [CNT_W-1:0] DW16 = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] DW8  = CNT_W'(BYTE_W);

    typedef struct packed {
        mw_state_e           state;
        logic [1:0]          op;
        logic                org16;
        logic [CNT_W-1:0]    cnt;
        logic [BADDR_W-1:0]  ash;
        logic [WORD_W-1:0]   dsh;
        logic [RSH_W-1:0]    rsh;
        logic                en;
        logic                stat;
        logic [PCNT_W-1:0]   pcnt;
        logic                wr;
        logic                all;
        logic                full;
        logic                bsel;
        logic [WADDR_W-1:0]  widx;
        logic [WORD_W-1:0]   wdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                sk_rise;
    logic [WORD_W-1:0]   rd_word;
    logic [WADDR_W-1:0]  rd_widx;
    logic [BYTE_W-1:0]   rd_byte;
    logic [BADDR_W-1:0]  ash_nx, a_src;
    logic [WORD_W-1:0]   dsh_nx;
    logic [CNT_W-1:0]    aw, dw;
    logic [1:0]          code;
    logic                launch, l_all;
    logic [WORD_W-1:0]   l_data;

    mw_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (sk_i),
        .rise_o (sk_rise)
    );

    assign ash_nx  = {ctl_q.ash[BADDR_W-2:0], di_i};
    assign dsh_nx  = {ctl_q.dsh[WORD_W-2:0], di_i};
    assign rd_widx = ctl_q.org16 ? ash_nx[WADDR_W-1:0] : ash_nx[BADDR_W-1:1];
    assign rd_byte = ash_nx[0] ? rd_word[WORD_W-1:BYTE_W] : rd_word[BYTE_W-1:0];

    mw_array #(
        .WORD_W  (WORD_W),
        .WADDR_W (WADDR_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctl_q.wr),
        .all_i   (ctl_q.all),
        .full_i  (ctl_q.full),
        .bsel_i  (ctl_q.bsel),
        .widx_i  (ctl_q.widx),
        .wdata_i (ctl_q.wdata),
        .ridx_i  (rd_widx),
        .rdata_o (rd_word)
    );

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.wr = 1'b0;
        aw       = ctl_q.org16 ? AW16 : AW8;
        dw       = ctl_q.org16 ? DW16 : DW8;
        code     = ctl_q.org16 ? ash_nx[WADDR_W-1 -: 2] : ash_nx[BADDR_W-1 -: 2];
        a_src    = (ctl_q.state == ST_ADDR) ? ash_nx : ctl_q.ash;
        launch   = 1'b0;
        l_all    = 1'b0;
        l_data   = '1;

        if (ctl_q.state == ST_BUSY) begin
            if (ctl_q.pcnt == '0) ctl_d.state = ST_IDLE;
            else                  ctl_d.pcnt  = ctl_q.pcnt - 1'b1;
        end else if (!cs_i) begin
            ctl_d.state = ST_IDLE;
        end else if (sk_rise) begin
            unique case (ctl_q.state)
                ST_IDLE: if (di_i) begin
                    ctl_d.state = ST_OPC;
                    ctl_d.cnt   = '0;
                    ctl_d.stat  = 1'b0;
                    ctl_d.org16 = org16_i;
                    ctl_d.ash   = '0;
                end
                ST_OPC: begin
                    ctl_d.op = {ctl_q.op[0], di_i};
                    if (ctl_q.cnt == CNT_W'(1)) begin
                        ctl_d.state = ST_ADDR;
                        ctl_d.cnt   = '0;
                    end else ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
                ST_ADDR: begin
                    ctl_d.ash = ash_nx;
                    if (ctl_q.cnt == aw - 1'b1) begin
                        ctl_d.cnt   = '0;
                        ctl_d.state = ST_IDLE;
                        unique case (ctl_q.op)
                            OP_READ: begin
                                ctl_d.state = ST_RDOUT;
                                ctl_d.cnt   = dw;
                                ctl_d.rsh   = ctl_q.org16 ? {1'b0, rd_word}
                                                          : {1'b0, rd_byte, {BYTE_W{1'b0}}};
                            end
                            OP_WRITE: ctl_d.state = ST_DATA;
                            OP_ERASE: launch = ctl_q.en;
                            default: begin
                                unique case (code)
                                    SP_UNLOCK: ctl_d.en = 1'b1;
                                    SP_LOCK:   ctl_d.en = 1'b0;
                                    SP_CLEAR: begin
                                        launch = ctl_q.en;
                                        l_all  = 1'b1;
                                    end
                                    default:   ctl_d.state = ST_DATA;
                                endcase
                            end
                        endcase
                    end else ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
                ST_DATA: begin
                    ctl_d.dsh = dsh_nx;
                    if (ctl_q.cnt == dw - 1'b1) begin
                        ctl_d.state = ST_IDLE;
                        launch      = ctl_q.en;
                        l_all       = (ctl_q.op == OP_SPECIAL);
                        l_data      = ctl_q.org16 ? dsh_nx
                                                  : {dsh_nx[BYTE_W-1:0], dsh_nx[BYTE_W-1:0]};
                    end else ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
                ST_RDOUT: begin
                    if (ctl_q.cnt == '0) ctl_d.state = ST_IDLE;
                    else begin
                        ctl_d.rsh = {ctl_q.rsh[RSH_W-2:0], 1'b0};
                        ctl_d.cnt = ctl_q.cnt - 1'b1;
                    end
                end
                default: ctl_d.state = ST_IDLE;
            endcase
        end

        if (launch) begin
            ctl_d.state = ST_BUSY;
            ctl_d.pcnt  = PCNT_W'(PROG_CYC - 1);
            ctl_d.stat  = 1'b1;
            ctl_d.wr    = 1'b1;
            ctl_d.all   = l_all;
            ctl_d.full  = ctl_q.org16;
            ctl_d.widx  = ctl_q.org16 ? a_src[WADDR_W-1:0] : a_src[BADDR_W-1:1];
            ctl_d.bsel  = a_src[0];
            ctl_d.wdata = l_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign do_o    = (ctl_q.state == ST_RDOUT) ? ctl_q.rsh[RSH_W-1] : (ctl_q.state != ST_BUSY);
    assign do_oe_o = cs_i & ((ctl_q.state == ST_RDOUT) | ctl_q.stat);

    // R4: a programming cycle may only start while unlocked
    assert_launch_unlocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state != ST_BUSY && ctl_d.state == ST_BUSY) |-> ctl_q.en);

    // R9: busy holds while the countdown is non-zero
    assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_BUSY && ctl_q.pcnt != '0) |=> ctl_q.state == ST_BUSY);

    // R6: first read slot is the dummy zero
    assert_dummy_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_RDOUT && ctl_q.cnt == (ctl_q.org16 ? DW16 : DW8)) |-> !do_o);

    // R10: no drive while an instruction is being shifted in
    assert_quiet_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_OPC || ctl_q.state == ST_ADDR || ctl_q.state == ST_DATA) |-> !do_oe_o);

    // R7: array writes are issued only on entry to the busy period
    assert_write_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.wr |-> ctl_q.state == ST_BUSY && ctl_q.pcnt == PCNT_W'(PROG_CYC - 1));
endmodule

// File: tb/mw_eeprom_bench.sv
module mw_eeprom_bench;
    localparam int PROG = 20;

    logic clk = 1'b0;
    logic rst_n, cs, sk, di, org16;
    logic do_o, do_oe;

    always #2.5 clk = ~clk;

    mw_eeprom #(.WORD_W(16), .WADDR_W(10), .PROG_CYC(PROG)) u_mw_eeprom (
        .clk (clk), .rst_n (rst_n), .cs_i (cs), .sk_i (sk), .di_i (di),
        .org16_i (org16), .do_o (do_o), .do_oe_o (do_oe)
    );

    logic [15:0] mdl [1024];
    bit    en, stat, rd, done;
    bit    rq[$];
    int    busy_left, compared, mism;
    string req;

    task automatic tick(); @(posedge clk); #1; endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    endtask

    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            bit eo, ed;
            eo = cs && (rd || stat);
            ed = rd ? rq[0] : (busy_left == 0);
            compared++;
            if (do_oe !== eo || (eo && do_o !== ed)) begin
                mism++;
                $display("FAIL %s: do_oe=%b do=%b expected do_oe=%b do=%b at %0t",
                         req, do_oe, do_o, eo, ed, $time);
            end
            if (busy_left > 0) busy_left--;
        end
    end

    function automatic int aw(); return org16 ? 10 : 11; endfunction
    function automatic int dw(); return org16 ? 16 : 8; endfunction

    task automatic sbit(input bit b);
        sk = 1'b0; di = b; tick();
        sk = 1'b1; tick();
        if (rd) begin
            void'(rq.pop_front());
            if (rq.size() == 0) rd = 1'b0;
        end
    endtask

    task automatic instr(input bit [1:0] op, input int addr, input bit hasd, input int data);
        cs = 1'b1; tick();
        sbit(1'b1); stat = 1'b0;
        sbit(op[1]); sbit(op[0]);
        for (int i = aw() - 1; i >= 0; i--) sbit(addr[i]);
        if (hasd) for (int i = dw() - 1; i >= 0; i--) sbit(data[i]);
    endtask

    task automatic finish_prog();
        if (en) begin busy_left = PROG; stat = 1'b1; end
        repeat (PROG + 4) tick();
        cs = 1'b0; tick();
    endtask

    task automatic mdl_store(input int a, input int d);
        if (org16) mdl[a] = d[15:0];
        else if (a[0]) mdl[a >> 1][15:8] = d[7:0];
        else mdl[a >> 1][7:0] = d[7:0];
    endtask

    task automatic do_read(input int a, input string tag);
        logic [15:0] v;
        req = tag;
        instr(2'b10, a, 1'b0, 0);
        v = org16 ? mdl[a] : (a[0] ? {mdl[a >> 1][15:8], 8'h00} : {mdl[a >> 1][7:0], 8'h00});
        rq.delete(); rq.push_back(1'b0);
        for (int i = 0; i < dw(); i++) rq.push_back(v[15 - i]);
        rd = 1'b1;
        for (int i = 0; i <= dw(); i++) sbit(1'b0);
        sbit(1'b0); sbit(1'b0);
        cs = 1'b0; tick();
    endtask

    task automatic do_write(input int a, input int d, input string tag);
        req = tag;
        instr(2'b01, a, 1'b1, d);
        if (en) mdl_store(a, d);
        finish_prog();
    endtask

    task automatic do_erase(input int a, input string tag);
        req = tag;
        instr(2'b11, a, 1'b0, 0);
        if (en) mdl_store(a, 'hFFFF);
        finish_prog();
    endtask

    task automatic do_special(input bit [1:0] c, input int d, input string tag);
        req = tag;
        instr(2'b00, int'(c) << (aw() - 2), (c == 2'b01), d);
        if (c == 2'b11) en = 1'b1;
        if (c == 2'b00) en = 1'b0;
        if (c == 2'b10 || c == 2'b01) begin
            if (en) for (int w = 0; w < 1024; w++)
                mdl[w] = (c == 2'b10) ? 16'hFFFF : (org16 ? d[15:0] : {d[7:0], d[7:0]});
            finish_prog();
        end else begin
            cs = 1'b0; tick();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mism++;
            $display("FAIL R2: watchdog expired, actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 1024; w++) mdl[w] = 16'hFFFF;
        rst_n = 1'b0; cs = 1'b0; sk = 1'b0; di = 1'b0; org16 = 1'b1;
        req = "R11";
        repeat (4) tick();
        compared++;
        if (do_oe !== 1'b0) begin
            mism++;
            $display("FAIL R11: do_oe in reset actual=%b expected=0", do_oe);
        end
        rst_n = 1'b1; tick();

        // R2: line activity with no start condition
        req = "R2";
        di = 1'b1;
        repeat (3) begin sk = 1'b1; tick(); sk = 1'b0; tick(); end
        cs = 1'b1;
        repeat (3) sbit(1'b0);
        cs = 1'b0; tick();

        do_read(5, "R11");                        // erased contents, R5 read while locked
        do_write(5, 16'h1234, "R4");              // locked: ignored
        do_special(2'b01, 16'h0000, "R4");        // write-all while locked
        do_erase(6, "R4");
        do_read(5, "R4");

        do_special(2'b11, 0, "R5");
        do_write(5, 16'hA5C3, "R7");
        do_read(5, "R6");

        // R9: clock and chip-select activity inside the busy window
        req = "R9";
        instr(2'b01, 9, 1'b1, 16'h0F0F);
        mdl_store(9, 16'h0F0F);
        busy_left = PROG; stat = 1'b1;
        repeat (3) tick();
        req = "R10";
        cs = 1'b0; repeat (2) tick();
        req = "R9";
        cs = 1'b1; tick();
        sbit(1'b1); sbit(1'b1);
        repeat (PROG) tick();
        cs = 1'b0; tick();
        cs = 1'b1; repeat (2) tick();               // ready flag still shown
        cs = 1'b0; tick();
        do_read(9, "R9");

        do_erase(5, "R7");
        do_read(5, "R7");

        // R1: byte organization against word organization
        org16 = 1'b0;
        do_write(21, 8'h5A, "R1");
        do_write(20, 8'h3C, "R1");
        do_read(21, "R1");
        org16 = 1'b1;
        do_read(10, "R1");

        // R3: partial write and aborted read
        req = "R3";
        cs = 1'b1; tick();
        sbit(1'b1); stat = 1'b0;
        sbit(1'b0); sbit(1'b1);
        repeat (4) sbit(1'b0);
        cs = 1'b0; tick();
        do_read(0, "R3");
        instr(2'b10, 10, 1'b0, 0);
        rq.delete(); rq.push_back(1'b0);
        for (int i = 0; i < 16; i++) rq.push_back(mdl[10][15 - i]);
        rd = 1'b1;
        sbit(1'b0); sbit(1'b0);
        cs = 1'b0; rd = 1'b0; rq.delete(); tick();
        do_read(10, "R3");

        // R8: fill and clear of the whole array
        do_special(2'b01, 16'h3C96, "R8");
        do_read(0, "R8");
        do_read(1023, "R8");
        do_special(2'b10, 0, "R8");
        do_read(512, "R8");
        org16 = 1'b0;
        do_special(2'b01, 8'h77, "R8");
        org16 = 1'b1;
        do_read(300, "R8");

        // R5: lock again, then a write is refused while reads still work
        do_special(2'b00, 0, "R5");
        do_write(300, 16'h0001, "R5");
        do_read(300, "R5");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule